// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns a 36-bit single-precision floating word into a 36-bit two's-complement integer. Bit 35 is the sign, bits 34:27 hold an excess-128 exponent and bits 26:0 hold the fraction. The binary point sits to the left of bit 26. A negative word is the two's complement of the whole matching positive word.

The block reads the exponent and works out where the binary point falls. It sign-extends the mantissa and adds one fraction constant chosen from the mode and the sign. It then shifts the sum arithmetically so that the integer part remains. Either it shifts left when the value is already a whole number, or it flags overflow when the magnitude needs more than 35 bits.

A request is one cycle of `req_valid` together with the word and the mode bit. The answer appears two clock edges later as a one-cycle `res_valid` pulse, with the integer and the overflow flag beside it.

Top module: `f2i_conv`

## Requirements
- R1: While reset is held and after it is released, `res_valid`, `res_ovf` and `res_int` are all zero until the first conversion completes.
- R2: A request sampled on one rising edge produces exactly one `res_valid` pulse, on the second rising edge after it.
- R3: Word layout: bit 35 is the sign, bits 34:27 are the exponent and bits 26:0 are the fraction. A negative word is the two's complement of the positive word of equal magnitude, and its exponent field reads back as the bitwise complement of the stored bits.
- R4: When the decoded exponent is 164 or more, `res_ovf` is 1 and `res_int` keeps the value it held before.
- R5: With `req_round`=1, rounding is half-up (ties go toward plus infinity). So 0.5 gives 1, -0.5 gives 0, 1.5 gives 2, -1.5 gives -1, 2.5 gives 3 and -2.5 gives -2.
- R6: With `req_round`=0 and a positive value, the fraction is discarded.
- R7: With `req_round`=0 and a negative value, the result rounds toward zero. The integer part moves up by one whenever the fraction is nonzero, so -1.5 gives -1.
- R8: A decoded exponent of 127 or less (magnitude below one half) gives 0 in both modes.
- R9: A decoded exponent from 155 to 163 converts exactly by a left shift of exponent-155. This covers the largest magnitude that fits, (2^27-1)*2^8.
- R10: The constant added below the binary point depends on mode and sign. In round mode it is exactly one half. In truncate mode it is zero for a positive value and an all-ones fraction for a negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request strobe |
| req_word | input | 36 | Floating word to convert |
| req_round | input | 1 | 1 = round half-up, 0 = truncate toward zero |
| res_valid | output | 1 | One-cycle pulse: result is ready |
| res_int | output | 36 | Two's-complement integer result (held on overflow) |
| res_ovf | output | 1 | Overflow flag for the conversion just finished |

## Verification
`res_valid`, `res_int` and `res_ovf` become valid together, two rising edges after the edge that sampled the request. The flag and the held integer are read in the same cycle as the pulse.

The bench drives each request on a falling edge and takes it away one falling edge later. It checks that the pulse is absent at that point. It then compares all three outputs on the following falling edge, and checks that the pulse has ended one cycle after that.

Expected integers come from a quotient-and-remainder model on magnitudes, which is a different method from the design's add-and-shift.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int WORD_W   = 36;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 27;
  localparam int EXP_BIAS = 128;
  localparam int MANT_W   = FRAC_W + 1;
  localparam int EXP_UNIT = EXP_BIAS + FRAC_W;   // exponent where the LSB weighs 1
  localparam int EXP_FIT  = EXP_BIAS + WORD_W;   // first exponent that cannot fit
  localparam int EXP_HALF = EXP_BIAS - 1;        // at or below: magnitude < 1/2
  localparam int SHIFT_CAP = WORD_W;             // right shifts beyond this all give 0
  localparam int SHIFT_W  = $clog2(SHIFT_CAP + 1);
  localparam int ACC_W    = 2 * WORD_W;

  typedef enum logic {MODE_TRUNC = 1'b0, MODE_ROUND = 1'b1} rnd_mode_e;

  typedef struct packed {
    logic                     neg;
    logic signed [WORD_W-1:0] mant;
    logic                     left;
    logic [SHIFT_W-1:0]       amt;
    rnd_mode_e                mode;
  } align_t;

  // Exponent field, complemented for negative words.
  function automatic logic [EXP_W-1:0] exp_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1] ? ~w[WORD_W-2 -: EXP_W] : w[WORD_W-2 -: EXP_W];
  endfunction

  // Signed mantissa: the fraction with the sign bit in front, sign-extended.
  function automatic logic signed [WORD_W-1:0] mant_of(input logic [WORD_W-1:0] w);
    return {{(WORD_W-MANT_W){w[WORD_W-1]}}, w[WORD_W-1], w[FRAC_W-1:0]};
  endfunction

  // Fraction constant placed below the binary point before the shift.
  function automatic logic [ACC_W-1:0] round_const(input rnd_mode_e mode,
                                                   input logic neg,
                                                   input logic [SHIFT_W-1:0] amt);
    logic [ACC_W-1:0] one;
    one = ACC_W'(1);
    if (amt == '0)              return '0;
    else if (mode == MODE_ROUND) return one << (amt - SHIFT_W'(1));
    else if (neg)               return (one << amt) - one;
    else                        return '0;
  endfunction

  // Sign-extend, add the constant, then shift the fraction bits away.
  function automatic logic [WORD_W-1:0] shift_down(input logic signed [WORD_W-1:0] mant,
                                                   input logic [ACC_W-1:0] c,
                                                   input logic [SHIFT_W-1:0] amt);
    logic signed [ACC_W-1:0] acc;
    acc = {{WORD_W{mant[WORD_W-1]}}, mant};
    acc = acc + $signed(c);
    acc = acc >>> amt;
    return acc[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] shift_up(input logic signed [WORD_W-1:0] mant,
                                                 input logic [SHIFT_W-1:0] amt);
    return mant <<< amt;
  endfunction
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              round_sel,
  output align_t            fields,
  output logic [EXP_W-1:0]  exp_dec,
  output logic              too_big,
  output logic              lost_all
);
  logic [EXP_W-1:0] e;
  int               up_amt;
  int               dn_amt;

  always_comb begin
    e        = exp_of(word);
    exp_dec  = e;
    too_big  = (int'(e) >= EXP_FIT);
    lost_all = (int'(e) <= EXP_HALF);
    up_amt   = int'(e) - EXP_UNIT;
    dn_amt   = EXP_UNIT - int'(e);
    if (dn_amt > SHIFT_CAP) dn_amt = SHIFT_CAP;

    fields.neg  = word[WORD_W-1];
    fields.mant = mant_of(word);
    fields.mode = round_sel ? MODE_ROUND : MODE_TRUNC;
    fields.left = (int'(e) >= EXP_UNIT);
    if (too_big)          fields.amt = '0;
    else if (fields.left) fields.amt = SHIFT_W'(up_amt);
    else                  fields.amt = SHIFT_W'(dn_amt);
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  align_t            fields,
  output logic [ACC_W-1:0]  rnd_const,
  output logic [WORD_W-1:0] int_out
);
  always_comb begin
    rnd_const = fields.left ? '0 : round_const(fields.mode, fields.neg, fields.amt);
    if (fields.left) int_out = shift_up(fields.mant, fields.amt);
    else             int_out = shift_down(fields.mant, rnd_const, fields.amt);
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [35:0]       req_word,
  input  logic              req_round,
  output logic              res_valid,
  output logic [35:0]       res_int,
  output logic              res_ovf
);
  // stage 1: decoded request
  align_t           dec_fields;
  logic [EXP_W-1:0] dec_exp;
  logic             dec_big;
  logic             dec_lost;

  align_t           s1_fields;
  logic [EXP_W-1:0] s1_exp;
  logic             s1_valid;
  logic             s1_big;
  logic             s1_lost;

  // stage 2: aligned and rounded integer
  logic [ACC_W-1:0]  rnd_const;
  logic [WORD_W-1:0] align_int;

  f2i_unpack u_unpack (
    .word      (req_word),
    .round_sel (req_round),
    .fields    (dec_fields),
    .exp_dec   (dec_exp),
    .too_big   (dec_big),
    .lost_all  (dec_lost)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_fields <= '0;
      s1_exp    <= '0;
      s1_big    <= 1'b0;
      s1_lost   <= 1'b0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_fields <= dec_fields;
        s1_exp    <= dec_exp;
        s1_big    <= dec_big;
        s1_lost   <= dec_lost;
      end
    end
  end

  f2i_align u_align (
    .fields    (s1_fields),
    .rnd_const (rnd_const),
    .int_out   (align_int)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_int   <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_ovf <= s1_big;
        if (!s1_big) res_int <= s1_lost ? '0 : align_int;
      end
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk
  import f2i_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              res_valid,
  input logic              res_ovf,
  input logic [35:0]       res_int,
  input logic              s1_valid,
  input logic              s1_lost,
  input align_t            s1_fields,
  input logic [ACC_W-1:0]  rnd_const,
  input logic [WORD_W-1:0] align_int
);
  // R2
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 res_valid);

  // R2
  latency_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid, 2));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovf) |-> $stable(res_int));

  // R8
  lost_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_lost) |-> (align_int == '0));

  // R10
  half_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_fields.left && s1_fields.amt != '0 && s1_fields.mode == MODE_ROUND)
      |-> ($countones(rnd_const) == 1));

  // R10
  pos_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_fields.mode == MODE_TRUNC && !s1_fields.neg) |-> (rnd_const == '0));

  // R10
  neg_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_fields.left && s1_fields.mode == MODE_TRUNC && s1_fields.neg)
      |-> ($countones(rnd_const) == int'(s1_fields.amt)));
endmodule

bind f2i_conv f2i_conv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .res_valid (res_valid),
  .res_ovf   (res_ovf),
  .res_int   (res_int),
  .s1_valid  (s1_valid),
  .s1_lost   (s1_lost),
  .s1_fields (s1_fields),
  .rnd_const (rnd_const),
  .align_int (align_int)
);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [35:0] req_word = '0;
  logic        req_round = 1'b0;
  logic        res_valid;
  logic [35:0] res_int;
  logic        res_ovf;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [35:0] held_int = '0;

  always #5 clk = ~clk;

  f2i_conv dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_round(req_round), .res_valid(res_valid), .res_int(res_int), .res_ovf(res_ovf)
  );

  function automatic logic [35:0] mk_word(bit s, int e, longint f);
    logic [35:0] p;
    p = {1'b0, e[7:0], f[26:0]};
    return s ? (~p + 36'd1) : p;
  endfunction

  // Model on magnitudes: integer part and remainder, then mode rules.
  function automatic longint ref_int(bit s, int e, longint f, bit rnd, output bit ovf);
    int k, sh;
    longint unit, ip, rem;
    ovf = (e >= 164);
    if (ovf) return 0;
    k = e - 155;
    if (k >= 0) begin
      ip = f <<< k;
      return s ? -ip : ip;
    end
    sh = -k;
    if (sh > 40) return 0;
    unit = longint'(1) <<< sh;
    ip = f / unit;
    rem = f % unit;
    if (!s) return (rnd && (2 * rem >= unit)) ? ip + 1 : ip;
    return (rnd && (2 * rem > unit)) ? -(ip + 1) : -ip;
  endfunction

  task automatic check(string tag, logic [35:0] got, logic [35:0] want);
    compared++;
    if (got !== want) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic convert(string tag, bit s, int e, longint f, bit rnd);
    bit ovf;
    longint v;
    v = ref_int(s, e, f, rnd, ovf);
    @(negedge clk);
    req_word = mk_word(s, e, f);
    req_round = rnd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({"R2 early pulse ", tag}, 36'(res_valid), 36'd0);
    @(negedge clk);
    check({"R2 valid ", tag}, 36'(res_valid), 36'd1);
    check({"R4 ovf flag ", tag}, 36'(res_ovf), 36'(ovf));
    if (!ovf) held_int = 36'(v);
    check({"value ", tag}, res_int, held_int);
    @(negedge clk);
    check({"R2 single pulse ", tag}, 36'(res_valid), 36'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 36'(res_valid), 36'd0);
    check("R1 int", res_int, 36'd0);
    check("R1 ovf", 36'(res_ovf), 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {34'd0, res_valid, res_ovf}, 36'd0);

    // R5 round half-up, R3 negative decoding
    convert("R5 +0.5 round", 0, 128, 1 << 26, 1);
    convert("R5 R3 -0.5 round", 1, 128, 1 << 26, 1);
    convert("R5 +1.5 round", 0, 129, 3 << 25, 1);
    convert("R5 R3 -1.5 round", 1, 129, 3 << 25, 1);
    convert("R5 +2.5 round", 0, 130, 5 << 24, 1);
    convert("R5 -2.5 round", 1, 130, 5 << 24, 1);
    // R6 / R7 truncate, R10 constant choice
    convert("R6 R10 +0.5 trunc", 0, 128, 1 << 26, 0);
    convert("R7 R10 -0.5 trunc", 1, 128, 1 << 26, 0);
    convert("R6 +1.5 trunc", 0, 129, 3 << 25, 0);
    convert("R7 -1.5 trunc", 1, 129, 3 << 25, 0);
    convert("R7 -2.5 trunc", 1, 130, 5 << 24, 0);
    // R9 exact range up to the largest fitting magnitude
    convert("R9 max pos round", 0, 163, (1 << 27) - 1, 1);
    convert("R9 max neg trunc", 1, 163, (1 << 27) - 1, 0);
    convert("R9 unit exp", 0, 155, 1 << 26, 0);
    // R4 just beyond: flag set, previous integer held
    convert("R4 beyond pos", 0, 164, 1 << 26, 1);
    convert("R4 beyond neg", 1, 200, (1 << 27) - 1, 0);
    // R8 everything below the point
    convert("R8 exp127 round", 0, 127, (1 << 27) - 1, 1);
    convert("R8 exp127 neg round", 1, 127, (1 << 27) - 1, 1);
    convert("R8 tiny neg trunc", 1, 60, 1 << 26, 0);
    convert("R8 zero word", 0, 0, 0, 1);

    for (int i = 0; i < 400; i++) begin
      bit s, rnd;
      int e;
      longint f;
      s = 1'($urandom);
      rnd = 1'($urandom);
      e = 120 + int'($urandom % 50);
      f = longint'($urandom % (1 << 26)) | (longint'(1) << 26);
      convert("R3 R5 R6 R7 random", s, e, f, rnd);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule